// File: doc/BRIEF.md
# Near-Bank Processing-in-Memory Command Scheduler

This block schedules work for one memory bank that carries its own compute logic. It takes two kinds of request. A compute request names one subarray. A transfer request names a source and a destination subarray, and the row is copied between them over a segmented bus inside the bank. Each kind of request waits in its own queue. One compute engine and one transfer engine take requests from the heads of their queues. Each engine emits a timed sequence of commands on its own command channel and raises a tagged done pulse when the sequence ends. The two engines run at the same time unless their requests touch the same subarray.

The bank bus has `NUM_SEG` segments. Segment i joins subarray i to subarray i+1. A transfer holds every segment between its two endpoint subarrays. A subarray in use by one engine is locked against the other engine. When the two queue heads collide on a subarray and both engines are free in the same cycle, a round-robin pointer decides which one starts. All phase lengths are elaboration parameters counted in clock cycles.

Top module: `pim_bank_sched`

## Requirements
- R1: Each request queue accepts a request on a clock edge where its valid and ready are both high. Ready is low exactly when `QDEPTH` (default 4) accepted requests are still waiting and have not started. A full queue never blocks the other queue.
- R2: A compute request starts in the first cycle in which its queue head is valid, the compute engine is idle and the start is allowed. Activate-compute (code 1) appears on `cCmdOp` in the next cycle, called cycle A. Row-precharge (code 2) appears at A+T_RCD+T_OP. `compDone` pulses for one cycle at A+T_RCD+T_OP+T_RP. The engine may start its next request in that same done cycle.
- R3: A transfer starts under the same conditions on its own engine. Activate-shared-row (code 3) with the source subarray appears at cycle A. A second activate-shared-row (code 3) with the destination subarray appears at A+T_ACTS-T_OVL, so the two activates overlap by T_OVL cycles. Bus-sense (code 4) appears T_ACTS cycles after the second activate. Bus-precharge (code 5) appears T_SENSE cycles after bus-sense. `xferDone` pulses T_PREB cycles after bus-precharge. Bus-sense and bus-precharge carry the source subarray.
- R4: `busSegHeld[i]` is high from cycle A of a transfer up to the cycle before its done pulse, for every i with min(src,dst) <= i < max(src,dst). All bits are zero at the done cycle and whenever no transfer is active.
- R5: A compute request whose subarray is the source or destination of the active transfer does not start until that transfer's done cycle. A transfer whose source or destination is the subarray of the active compute does not start until that compute's done cycle.
- R6: When both engines could start in the same cycle and the compute head's subarray equals the transfer head's source or destination, only one starts. After reset the compute request wins the first such clash. After each clash the loser of that clash wins the next one.
- R7: Requests that touch different subarrays run concurrently, and each queue starts its requests in arrival order.
- R8: Every non-zero command carries the tag of its request. `compDoneTag` and `xferDoneTag` carry that tag in the done cycle.
- R9: While reset is high and in the first cycle after it, both readies are high, both command channels show code 0, the done pulses are low and `busSegHeld` is zero.
- R10: The compute channel shows only codes 0, 1 and 2. The transfer channel shows only codes 0, 3, 4 and 5. Code 0 means no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cReqValid | input | 1 | Compute request valid |
| cReqReady | output | 1 | Compute queue can accept a request |
| cReqSub | input | SUB_W | Compute target subarray |
| cReqTag | input | TAG_W | Compute request tag |
| xReqValid | input | 1 | Transfer request valid |
| xReqReady | output | 1 | Transfer queue can accept a request |
| xReqSrc | input | SUB_W | Transfer source subarray |
| xReqDst | input | SUB_W | Transfer destination subarray |
| xReqTag | input | TAG_W | Transfer request tag |
| cCmdOp | output | 3 | Compute channel command code |
| cCmdSub | output | SUB_W | Subarray of the compute command |
| cCmdTag | output | TAG_W | Tag of the compute command |
| xCmdOp | output | 3 | Transfer channel command code |
| xCmdSub | output | SUB_W | Subarray of the transfer command |
| xCmdTag | output | TAG_W | Tag of the transfer command |
| busSegHeld | output | NUM_SEG | Bus segments held by the active transfer |
| compDone | output | 1 | Compute completion pulse |
| compDoneTag | output | TAG_W | Tag of the completed compute |
| xferDone | output | 1 | Transfer completion pulse |
| xferDoneTag | output | TAG_W | Tag of the completed transfer |

## Verification
Two things can happen in the same cycle: a compute start and a transfer start, whether or not they collide, and a command on each channel. The bench pushes a compute and a transfer request in the same cycle while both engines are idle. It does this once on disjoint subarrays, where both must start together, and twice on a shared subarray, where the winner must alternate. It also queues a held compute behind a running transfer, so that the compute's activate must follow the transfer's done cycle by exactly one cycle. A behavioural model predicts every output in every cycle, and any difference in timing or winner shows up as a wrong command code in a particular cycle.

// File: rtl/pim_sched_pkg.sv
package pim_sched_pkg;

  typedef enum logic [2:0] {
    CMD_NONE    = 3'd0,
    CMD_ACT_C   = 3'd1,
    CMD_PRE_R   = 3'd2,
    CMD_ACT_S   = 3'd3,
    CMD_SENSE_B = 3'd4,
    CMD_PRE_B   = 3'd5
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cStart;
    logic xStart;
    cmd_e cOp;
    cmd_e xOp;
    logic xDstSel;
    logic cDone;
    logic xDone;
  } strobe_t;

  // conflict flags from datapath to control
  typedef struct packed {
    logic cBlocked;
    logic xBlocked;
    logic headClash;
  } status_t;

endpackage

// File: rtl/pim_req_fifo.sv
module pim_req_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic             ready,
  output logic             headValid,
  output logic [WIDTH-1:0] headData
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] fill;
  logic             doPush, doPop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign ready     = fill < CNT_W'(DEPTH);
  assign headValid = fill != '0;
  assign headData  = store[rdPtr];
  assign doPush    = push && ready;
  assign doPop     = pop && headValid;

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPtr <= '0;
      wrPtr <= '0;
      fill  <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

endmodule

// File: rtl/pim_sched_ctrl.sv
module pim_sched_ctrl
  import pim_sched_pkg::*;
#(
  parameter int T_RCD   = 3,
  parameter int T_OP    = 4,
  parameter int T_RP    = 2,
  parameter int T_ACTS  = 3,
  parameter int T_OVL   = 1,
  parameter int T_SENSE = 2,
  parameter int T_PREB  = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    cHeadValid,
  input  logic    xHeadValid,
  input  status_t st,
  output strobe_t sb
);

  localparam int M1    = (T_RCD > T_OP) ? T_RCD : T_OP;
  localparam int M2    = (M1 > T_RP) ? M1 : T_RP;
  localparam int M3    = (M2 > T_ACTS) ? M2 : T_ACTS;
  localparam int M4    = (M3 > T_SENSE) ? M3 : T_SENSE;
  localparam int MAXT  = (M4 > T_PREB) ? M4 : T_PREB;
  localparam int CNT_W = $clog2(MAXT + 1);

  typedef enum logic [1:0] {C_IDLE, C_RCD, C_OP, C_RP} cstate_e;
  typedef enum logic [2:0] {X_IDLE, X_ACT1, X_ACT2, X_SENSE, X_PREB} xstate_e;

  cstate_e          cState;
  xstate_e          xState;
  logic [CNT_W-1:0] cCnt, xCnt;
  logic             prioC;
  logic             cCan, xCan, clash;
  logic             cZero, xZero;

  assign cZero = cCnt == '0;
  assign xZero = xCnt == '0;

  always_comb begin
    sb    = '0;
    cCan  = cHeadValid && (cState == C_IDLE) && !st.cBlocked;
    xCan  = xHeadValid && (xState == X_IDLE) && !st.xBlocked;
    clash = cCan && xCan && st.headClash;
    sb.cStart = cCan && (!clash || prioC);
    sb.xStart = xCan && (!clash || !prioC);

    if (sb.cStart)                    sb.cOp = CMD_ACT_C;
    else if (cState == C_OP && cZero) sb.cOp = CMD_PRE_R;
    else                              sb.cOp = CMD_NONE;
    sb.cDone = (cState == C_RP) && cZero;

    if (sb.xStart)                       sb.xOp = CMD_ACT_S;
    else if (xState == X_ACT1 && xZero) begin
      sb.xOp     = CMD_ACT_S;
      sb.xDstSel = 1'b1;
    end
    else if (xState == X_ACT2 && xZero)  sb.xOp = CMD_SENSE_B;
    else if (xState == X_SENSE && xZero) sb.xOp = CMD_PRE_B;
    else                                 sb.xOp = CMD_NONE;
    sb.xDone = (xState == X_PREB) && xZero;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cState <= C_IDLE;
      xState <= X_IDLE;
      cCnt   <= '0;
      xCnt   <= '0;
      prioC  <= 1'b1;
    end else begin
      if (clash) prioC <= sb.xStart;

      case (cState)
        C_IDLE: if (sb.cStart) begin
          cState <= C_RCD;
          cCnt   <= CNT_W'(T_RCD - 1);
        end
        C_RCD: if (cZero) begin
          cState <= C_OP;
          cCnt   <= CNT_W'(T_OP - 1);
        end else cCnt <= cCnt - 1'b1;
        C_OP: if (cZero) begin
          cState <= C_RP;
          cCnt   <= CNT_W'(T_RP - 1);
        end else cCnt <= cCnt - 1'b1;
        C_RP: if (cZero) cState <= C_IDLE;
              else cCnt <= cCnt - 1'b1;
        default: cState <= C_IDLE;
      endcase

      case (xState)
        X_IDLE: if (sb.xStart) begin
          xState <= X_ACT1;
          xCnt   <= CNT_W'(T_ACTS - T_OVL - 1);
        end
        X_ACT1: if (xZero) begin
          xState <= X_ACT2;
          xCnt   <= CNT_W'(T_ACTS - 1);
        end else xCnt <= xCnt - 1'b1;
        X_ACT2: if (xZero) begin
          xState <= X_SENSE;
          xCnt   <= CNT_W'(T_SENSE - 1);
        end else xCnt <= xCnt - 1'b1;
        X_SENSE: if (xZero) begin
          xState <= X_PREB;
          xCnt   <= CNT_W'(T_PREB - 1);
        end else xCnt <= xCnt - 1'b1;
        X_PREB: if (xZero) xState <= X_IDLE;
                else xCnt <= xCnt - 1'b1;
        default: xState <= X_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pim_sched_dp.sv
module pim_sched_dp
  import pim_sched_pkg::*;
#(
  parameter int NUM_SEG = 4,
  parameter int SUB_W   = 3,
  parameter int TAG_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            sb,
  input  logic [SUB_W-1:0]   cHeadSub,
  input  logic [TAG_W-1:0]   cHeadTag,
  input  logic [SUB_W-1:0]   xHeadSrc,
  input  logic [SUB_W-1:0]   xHeadDst,
  input  logic [TAG_W-1:0]   xHeadTag,
  output status_t            st,
  output logic [2:0]         cCmdOp,
  output logic [SUB_W-1:0]   cCmdSub,
  output logic [TAG_W-1:0]   cCmdTag,
  output logic [2:0]         xCmdOp,
  output logic [SUB_W-1:0]   xCmdSub,
  output logic [TAG_W-1:0]   xCmdTag,
  output logic [NUM_SEG-1:0] busSegHeld,
  output logic               compDone,
  output logic [TAG_W-1:0]   compDoneTag,
  output logic               xferDone,
  output logic [TAG_W-1:0]   xferDoneTag
);

  logic [SUB_W-1:0] cSubQ, xSrcQ, xDstQ, segLo, segHi;
  logic [TAG_W-1:0] cTagQ, xTagQ;
  logic             cAct, xAct;

  assign st.cBlocked  = xAct && (cHeadSub == xSrcQ || cHeadSub == xDstQ);
  assign st.xBlocked  = cAct && (xHeadSrc == cSubQ || xHeadDst == cSubQ);
  assign st.headClash = (cHeadSub == xHeadSrc) || (cHeadSub == xHeadDst);

  assign segLo = (xSrcQ < xDstQ) ? xSrcQ : xDstQ;
  assign segHi = (xSrcQ < xDstQ) ? xDstQ : xSrcQ;

  for (genvar g = 0; g < NUM_SEG; g++) begin : gSeg
    assign busSegHeld[g] = xAct && (SUB_W'(g) >= segLo) && (SUB_W'(g) < segHi);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cAct     <= 1'b0;
      xAct     <= 1'b0;
      cSubQ    <= '0;
      cTagQ    <= '0;
      xSrcQ    <= '0;
      xDstQ    <= '0;
      xTagQ    <= '0;
      cCmdOp   <= CMD_NONE;
      cCmdSub  <= '0;
      cCmdTag  <= '0;
      xCmdOp   <= CMD_NONE;
      xCmdSub  <= '0;
      xCmdTag  <= '0;
      compDone <= 1'b0;
      compDoneTag <= '0;
      xferDone <= 1'b0;
      xferDoneTag <= '0;
    end else begin
      if (sb.cStart) begin
        cAct  <= 1'b1;
        cSubQ <= cHeadSub;
        cTagQ <= cHeadTag;
      end else if (sb.cDone) cAct <= 1'b0;

      if (sb.xStart) begin
        xAct  <= 1'b1;
        xSrcQ <= xHeadSrc;
        xDstQ <= xHeadDst;
        xTagQ <= xHeadTag;
      end else if (sb.xDone) xAct <= 1'b0;

      cCmdOp  <= sb.cOp;
      cCmdSub <= sb.cStart ? cHeadSub : cSubQ;
      cCmdTag <= sb.cStart ? cHeadTag : cTagQ;
      xCmdOp  <= sb.xOp;
      xCmdSub <= sb.xStart ? xHeadSrc : (sb.xDstSel ? xDstQ : xSrcQ);
      xCmdTag <= sb.xStart ? xHeadTag : xTagQ;

      compDone    <= sb.cDone;
      compDoneTag <= cTagQ;
      xferDone    <= sb.xDone;
      xferDoneTag <= xTagQ;
    end
  end

endmodule

// File: rtl/pim_bank_sched.sv
module pim_bank_sched
  import pim_sched_pkg::*;
#(
  parameter int NUM_SEG = 4,
  parameter int TAG_W   = 4,
  parameter int QDEPTH  = 4,
  parameter int T_RCD   = 3,
  parameter int T_OP    = 4,
  parameter int T_RP    = 2,
  parameter int T_ACTS  = 3,
  parameter int T_OVL   = 1,
  parameter int T_SENSE = 2,
  parameter int T_PREB  = 2,
  localparam int NUM_SUB = NUM_SEG + 1,
  localparam int SUB_W   = $clog2(NUM_SUB)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cReqValid,
  output logic               cReqReady,
  input  logic [SUB_W-1:0]   cReqSub,
  input  logic [TAG_W-1:0]   cReqTag,
  input  logic               xReqValid,
  output logic               xReqReady,
  input  logic [SUB_W-1:0]   xReqSrc,
  input  logic [SUB_W-1:0]   xReqDst,
  input  logic [TAG_W-1:0]   xReqTag,
  output logic [2:0]         cCmdOp,
  output logic [SUB_W-1:0]   cCmdSub,
  output logic [TAG_W-1:0]   cCmdTag,
  output logic [2:0]         xCmdOp,
  output logic [SUB_W-1:0]   xCmdSub,
  output logic [TAG_W-1:0]   xCmdTag,
  output logic [NUM_SEG-1:0] busSegHeld,
  output logic               compDone,
  output logic [TAG_W-1:0]   compDoneTag,
  output logic               xferDone,
  output logic [TAG_W-1:0]   xferDoneTag
);

  localparam int CW = SUB_W + TAG_W;
  localparam int XW = 2 * SUB_W + TAG_W;

  strobe_t         sb;
  status_t         st;
  logic            cHeadValid, xHeadValid;
  logic [CW-1:0]   cHead;
  logic [XW-1:0]   xHead;

  pim_req_fifo #(.WIDTH(CW), .DEPTH(QDEPTH)) u_cQueue (
    .clk(clk), .rst(rst), .push(cReqValid), .pushData({cReqSub, cReqTag}),
    .pop(sb.cStart), .ready(cReqReady), .headValid(cHeadValid), .headData(cHead)
  );

  pim_req_fifo #(.WIDTH(XW), .DEPTH(QDEPTH)) u_xQueue (
    .clk(clk), .rst(rst), .push(xReqValid), .pushData({xReqSrc, xReqDst, xReqTag}),
    .pop(sb.xStart), .ready(xReqReady), .headValid(xHeadValid), .headData(xHead)
  );

  pim_sched_ctrl #(
    .T_RCD(T_RCD), .T_OP(T_OP), .T_RP(T_RP), .T_ACTS(T_ACTS),
    .T_OVL(T_OVL), .T_SENSE(T_SENSE), .T_PREB(T_PREB)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cHeadValid(cHeadValid), .xHeadValid(xHeadValid),
    .st(st), .sb(sb)
  );

  pim_sched_dp #(.NUM_SEG(NUM_SEG), .SUB_W(SUB_W), .TAG_W(TAG_W)) u_dp (
    .clk(clk), .rst(rst), .sb(sb),
    .cHeadSub(cHead[CW-1:TAG_W]), .cHeadTag(cHead[TAG_W-1:0]),
    .xHeadSrc(xHead[XW-1:SUB_W+TAG_W]), .xHeadDst(xHead[SUB_W+TAG_W-1:TAG_W]),
    .xHeadTag(xHead[TAG_W-1:0]),
    .st(st),
    .cCmdOp(cCmdOp), .cCmdSub(cCmdSub), .cCmdTag(cCmdTag),
    .xCmdOp(xCmdOp), .xCmdSub(xCmdSub), .xCmdTag(xCmdTag),
    .busSegHeld(busSegHeld),
    .compDone(compDone), .compDoneTag(compDoneTag),
    .xferDone(xferDone), .xferDoneTag(xferDoneTag)
  );

endmodule

// File: rtl/pim_sched_chk.sv
module pim_sched_chk #(
  parameter int NUM_SEG = 4,
  parameter int SUB_W   = 3,
  parameter int TAG_W   = 4,
  parameter int T_RCD   = 3,
  parameter int T_OP    = 4,
  parameter int T_RP    = 2,
  parameter int T_ACTS  = 3,
  parameter int T_OVL   = 1,
  parameter int T_SENSE = 2,
  parameter int T_PREB  = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               cReqValid,
  input logic               cReqReady,
  input logic               xReqValid,
  input logic               xReqReady,
  input logic [2:0]         cCmdOp,
  input logic [SUB_W-1:0]   cCmdSub,
  input logic [TAG_W-1:0]   cCmdTag,
  input logic [2:0]         xCmdOp,
  input logic [SUB_W-1:0]   xCmdSub,
  input logic [TAG_W-1:0]   xCmdTag,
  input logic [NUM_SEG-1:0] busSegHeld,
  input logic               compDone,
  input logic [TAG_W-1:0]   compDoneTag,
  input logic               xferDone,
  input logic [TAG_W-1:0]   xferDoneTag
);

  logic [15:0]        sinceActC, sincePreR, sinceActS, sinceSense, sincePreB;
  logic               xTrk, xDstKnown;
  logic [SUB_W-1:0]   xSrcT, xDstT;
  logic [TAG_W-1:0]   cTagT, xTagT;
  logic [NUM_SEG-1:0] segLow;

  function automatic logic [15:0] bump(input logic [15:0] v);
    return (v == 16'hffff) ? v : v + 16'd1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceActC  <= '0;
      sincePreR  <= '0;
      sinceActS  <= '0;
      sinceSense <= '0;
      sincePreB  <= '0;
      xTrk       <= 1'b0;
      xDstKnown  <= 1'b0;
      xSrcT      <= '0;
      xDstT      <= '0;
      cTagT      <= '0;
      xTagT      <= '0;
    end else begin
      sinceActC  <= (cCmdOp == 3'd1) ? 16'd1 : bump(sinceActC);
      sincePreR  <= (cCmdOp == 3'd2) ? 16'd1 : bump(sincePreR);
      sinceSense <= (xCmdOp == 3'd4) ? 16'd1 : bump(sinceSense);
      sincePreB  <= (xCmdOp == 3'd5) ? 16'd1 : bump(sincePreB);
      if (cCmdOp == 3'd1) cTagT <= cCmdTag;
      if (xCmdOp == 3'd3 && !xTrk) begin
        xTrk      <= 1'b1;
        xDstKnown <= 1'b0;
        xSrcT     <= xCmdSub;
        xTagT     <= xCmdTag;
        sinceActS <= 16'd1;
      end else begin
        sinceActS <= bump(sinceActS);
        if (xCmdOp == 3'd3) begin
          xDstKnown <= 1'b1;
          xDstT     <= xCmdSub;
        end
        if (xferDone) xTrk <= 1'b0;
      end
    end
  end

  assign segLow = busSegHeld & (~busSegHeld + 1'b1);

  assert_ready_drop_c_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(cReqReady) |-> $past(cReqValid));
  assert_ready_drop_x_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(xReqReady) |-> $past(xReqValid));
  assert_pre_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    (cCmdOp == 3'd2) |-> (sinceActC == 16'(T_RCD + T_OP)));
  assert_cdone_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    compDone |-> (sincePreR == 16'(T_RP)));
  assert_second_act_R3: assert property (@(posedge clk) disable iff (rst)
    (xCmdOp == 3'd3 && xTrk) |-> (sinceActS == 16'(T_ACTS - T_OVL)));
  assert_sense_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    (xCmdOp == 3'd4) |-> (sinceActS == 16'(2 * T_ACTS - T_OVL)));
  assert_preb_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    (xCmdOp == 3'd5) |-> (sinceSense == 16'(T_SENSE)));
  assert_xdone_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    xferDone |-> (sincePreB == 16'(T_PREB)));
  assert_seg_contig_R4: assert property (@(posedge clk) disable iff (rst)
    ((busSegHeld + segLow) & busSegHeld) == '0);
  assert_seg_owner_R4: assert property (@(posedge clk) disable iff (rst)
    (busSegHeld != '0) |-> (xTrk || xCmdOp == 3'd3));
  assert_seg_release_R4: assert property (@(posedge clk) disable iff (rst)
    xferDone |-> (busSegHeld == '0));
  assert_row_lock_R5: assert property (@(posedge clk) disable iff (rst)
    (cCmdOp == 3'd1 && xTrk) |-> (cCmdSub != xSrcT && (!xDstKnown || cCmdSub != xDstT)));
  assert_cdone_tag_R8: assert property (@(posedge clk) disable iff (rst)
    compDone |-> (compDoneTag == cTagT));
  assert_xdone_tag_R8: assert property (@(posedge clk) disable iff (rst)
    xferDone |-> (xferDoneTag == xTagT));
  assert_ccodes_R10: assert property (@(posedge clk) disable iff (rst)
    cCmdOp <= 3'd2);
  assert_xcodes_R10: assert property (@(posedge clk) disable iff (rst)
    (xCmdOp == 3'd0) || (xCmdOp >= 3'd3 && xCmdOp <= 3'd5));

endmodule

bind pim_bank_sched pim_sched_chk #(
  .NUM_SEG(NUM_SEG), .SUB_W(SUB_W), .TAG_W(TAG_W),
  .T_RCD(T_RCD), .T_OP(T_OP), .T_RP(T_RP), .T_ACTS(T_ACTS),
  .T_OVL(T_OVL), .T_SENSE(T_SENSE), .T_PREB(T_PREB)
) u_chk (
  .clk(clk), .rst(rst),
  .cReqValid(cReqValid), .cReqReady(cReqReady),
  .xReqValid(xReqValid), .xReqReady(xReqReady),
  .cCmdOp(cCmdOp), .cCmdSub(cCmdSub), .cCmdTag(cCmdTag),
  .xCmdOp(xCmdOp), .xCmdSub(xCmdSub), .xCmdTag(xCmdTag),
  .busSegHeld(busSegHeld),
  .compDone(compDone), .compDoneTag(compDoneTag),
  .xferDone(xferDone), .xferDoneTag(xferDoneTag)
);

// File: tb/test_pim_bank_sched.sv
module test_pim_bank_sched;

  localparam int NUM_SEG = 4, TAG_W = 4, QDEPTH = 4;
  localparam int SUB_W = 3;
  localparam int T_RCD = 3, T_OP = 4, T_RP = 2;
  localparam int T_ACTS = 3, T_OVL = 1, T_SENSE = 2, T_PREB = 2;
  // timeline offsets from the first command, per R2 and R3
  localparam int CPRE = T_RCD + T_OP;
  localparam int CTOT = CPRE + T_RP;
  localparam int XD1  = T_ACTS - T_OVL;
  localparam int XD2  = XD1 + T_ACTS;
  localparam int XD3  = XD2 + T_SENSE;
  localparam int XTOT = XD3 + T_PREB;
  // command codes from R10
  localparam int OP_ACT_C = 1, OP_PRE_R = 2, OP_ACT_S = 3, OP_SENSE = 4, OP_PRE_B = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic cReqValid = 1'b0, xReqValid = 1'b0;
  logic [SUB_W-1:0] cReqSub = '0, xReqSrc = '0, xReqDst = '0;
  logic [TAG_W-1:0] cReqTag = '0, xReqTag = '0;
  logic cReqReady, xReqReady, compDone, xferDone;
  logic [2:0] cCmdOp, xCmdOp;
  logic [SUB_W-1:0] cCmdSub, xCmdSub;
  logic [TAG_W-1:0] cCmdTag, xCmdTag, compDoneTag, xferDoneTag;
  logic [NUM_SEG-1:0] busSegHeld;

  always #10 clk = ~clk;

  pim_bank_sched #(
    .NUM_SEG(NUM_SEG), .TAG_W(TAG_W), .QDEPTH(QDEPTH),
    .T_RCD(T_RCD), .T_OP(T_OP), .T_RP(T_RP), .T_ACTS(T_ACTS),
    .T_OVL(T_OVL), .T_SENSE(T_SENSE), .T_PREB(T_PREB)
  ) i_pim_bank_sched (
    .clk(clk), .rst(rst),
    .cReqValid(cReqValid), .cReqReady(cReqReady), .cReqSub(cReqSub), .cReqTag(cReqTag),
    .xReqValid(xReqValid), .xReqReady(xReqReady), .xReqSrc(xReqSrc), .xReqDst(xReqDst),
    .xReqTag(xReqTag),
    .cCmdOp(cCmdOp), .cCmdSub(cCmdSub), .cCmdTag(cCmdTag),
    .xCmdOp(xCmdOp), .xCmdSub(xCmdSub), .xCmdTag(xCmdTag),
    .busSegHeld(busSegHeld),
    .compDone(compDone), .compDoneTag(compDoneTag),
    .xferDone(xferDone), .xferDoneTag(xferDoneTag)
  );

  int errors = 0, checks = 0;
  bit finished = 1'b0;
  string phase = "init";

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] %s: actual=%0d expected=%0d", req, phase, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct { int sub; int tag; } creq_t;
  typedef struct { int src; int dst; int tag; } xreq_t;
  creq_t cq[$];
  xreq_t xq[$];
  int cAge = -1, xAge = -1;
  int mcSub, mcTag, mxSrc, mxDst, mxTag;
  bit prioC = 1'b1;

  always @(posedge clk) begin
    if (rst) begin
      cq.delete(); xq.delete();
      cAge = -1; xAge = -1; prioC = 1'b1;
    end else begin
      bit cIdle, xIdle, cCan, xCan, clash, cGo, xGo, cRdy, xRdy;
      cIdle = (cAge < 0) || (cAge >= CTOT);
      xIdle = (xAge < 0) || (xAge >= XTOT);
      cRdy = cq.size() < QDEPTH;
      xRdy = xq.size() < QDEPTH;
      cCan = cq.size() > 0 && cIdle &&
             !(!xIdle && (cq[0].sub == mxSrc || cq[0].sub == mxDst));
      xCan = xq.size() > 0 && xIdle &&
             !(!cIdle && (xq[0].src == mcSub || xq[0].dst == mcSub));
      clash = cCan && xCan && (cq[0].sub == xq[0].src || cq[0].sub == xq[0].dst);
      cGo = cCan && (!clash || prioC);
      xGo = xCan && (!clash || !prioC);
      if (clash) prioC = xGo;
      if (cAge >= 0) begin cAge++; if (cAge > CTOT) cAge = -1; end
      if (xAge >= 0) begin xAge++; if (xAge > XTOT) xAge = -1; end
      if (cGo) begin
        cAge = 0; mcSub = cq[0].sub; mcTag = cq[0].tag; void'(cq.pop_front());
      end
      if (xGo) begin
        xAge = 0; mxSrc = xq[0].src; mxDst = xq[0].dst; mxTag = xq[0].tag;
        void'(xq.pop_front());
      end
      if (cReqValid && cRdy) cq.push_back('{int'(cReqSub), int'(cReqTag)});
      if (xReqValid && xRdy) xq.push_back('{int'(xReqSrc), int'(xReqDst), int'(xReqTag)});
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      int eOp, eSeg, lo, hi;
      chk("R1", "cReqReady", cReqReady, cq.size() < QDEPTH);
      chk("R1", "xReqReady", xReqReady, xq.size() < QDEPTH);
      eOp = (cAge == 0) ? OP_ACT_C : (cAge == CPRE) ? OP_PRE_R : 0;
      chk("R2", "cCmdOp", cCmdOp, eOp);
      if (eOp != 0) begin
        chk("R2", "cCmdSub", cCmdSub, mcSub);
        chk("R8", "cCmdTag", cCmdTag, mcTag);
      end
      chk("R2", "compDone", compDone, cAge == CTOT);
      if (cAge == CTOT) chk("R8", "compDoneTag", compDoneTag, mcTag);
      eOp = (xAge == 0 || xAge == XD1) ? OP_ACT_S : (xAge == XD2) ? OP_SENSE :
            (xAge == XD3) ? OP_PRE_B : 0;
      chk("R3", "xCmdOp", xCmdOp, eOp);
      if (eOp != 0) begin
        chk("R3", "xCmdSub", xCmdSub, (xAge == XD1) ? mxDst : mxSrc);
        chk("R8", "xCmdTag", xCmdTag, mxTag);
      end
      chk("R3", "xferDone", xferDone, xAge == XTOT);
      if (xAge == XTOT) chk("R8", "xferDoneTag", xferDoneTag, mxTag);
      eSeg = 0;
      lo = (mxSrc < mxDst) ? mxSrc : mxDst;
      hi = (mxSrc < mxDst) ? mxDst : mxSrc;
      if (xAge >= 0 && xAge < XTOT)
        for (int i = 0; i < NUM_SEG; i++) if (i >= lo && i < hi) eSeg |= (1 << i);
      chk("R4", "busSegHeld", busSegHeld, eSeg);
    end
  end

  // ---------------- stimulus ----------------
  task automatic pushC(input int sub, input int tag);
    bit r;
    cReqValid = 1'b1; cReqSub = SUB_W'(sub); cReqTag = TAG_W'(tag);
    do begin r = cReqReady; @(posedge clk); end while (!r);
    @(negedge clk);
    cReqValid = 1'b0;
  endtask

  task automatic pushX(input int src, input int dst, input int tag);
    bit r;
    xReqValid = 1'b1; xReqSrc = SUB_W'(src); xReqDst = SUB_W'(dst); xReqTag = TAG_W'(tag);
    do begin r = xReqReady; @(posedge clk); end while (!r);
    @(negedge clk);
    xReqValid = 1'b0;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    phase = "R9 reset";
    chk("R9", "cReqReady in reset", cReqReady, 1);
    chk("R9", "cCmdOp in reset", cCmdOp, 0);
    chk("R9", "xCmdOp in reset", xCmdOp, 0);
    chk("R9", "busSegHeld in reset", busSegHeld, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", "xReqReady after reset", xReqReady, 1);
    chk("R9", "done pulses after reset", compDone | xferDone, 0);

    phase = "R2 single compute";
    pushC(2, 5); settle();
    phase = "R3 R4 single transfer";
    pushX(0, 3, 9); settle();
    phase = "R3 R4 reverse transfer";
    pushX(4, 1, 3); settle();

    phase = "R7 disjoint same cycle";
    fork pushC(4, 1); pushX(0, 2, 2); join
    settle();

    phase = "R6 clash compute wins";
    fork pushC(1, 6); pushX(1, 3, 7); join
    settle(); settle();
    phase = "R6 clash transfer wins";
    fork pushC(3, 8); pushX(2, 3, 10); join
    settle(); settle();

    phase = "R5 compute held by transfer";
    pushX(0, 2, 11); pushC(2, 12); settle(); settle();
    phase = "R5 transfer held by compute";
    pushC(3, 13); pushX(3, 1, 14); settle(); settle();

    phase = "R1 R7 queue fill and order";
    fork
      begin for (int k = 0; k < 7; k++) pushC(k % 5, k); end
      begin for (int k = 0; k < 6; k++) pushX(k % 2, 4 - (k % 3), 8 + k); end
    join
    repeat (250) @(negedge clk);

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

endmodule